// File: doc/BRIEF.md
# Frequency-Bin Beam Accumulator

This block sums the phase-adjusted spectra of many receive or transmit channels into a single beam, one frequency bin at a time. Each channel arrives as one pass: a run of complex samples, each tagged with its bin number. The pass is closed by a sample that carries the pass-end flag. For every accepted sample, the block reads the partial sum held for that bin, adds the sample, and writes the result back. Bins are kept in a dual-port store with one entry per bin. The real and imaginary halves travel through identical adder lanes.

The first pass of a beam overwrites its bins instead of adding to them, so no clear cycle is needed between beams. The beam is complete after 32 passes in serial mode. In grouped mode it is complete after 8 passes, because each input there is already the sum of four channels. When the beam is complete, the block stops accepting input and streams the finished sums out in bin order. It then starts a new beam.

Top module: `beam_acc_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low and the block is in pass 0, ready to accept samples.
- R2: In pass 0, each accepted sample stores its sign-extended value in its bin and disregards whatever that bin held before.
- R3: In passes after the first, each accepted sample is added to its bin's stored sum. The addition is two's complement modulo 2^22, and the real and imaginary parts are added independently.
- R4: Every sample sees the effect of all earlier samples to the same bin, including samples to that bin on directly consecutive cycles or with one idle cycle between them.
- R5: A pass ends when a sample with `in_last` high is accepted. A beam ends after 32 passes when the mode is serial (`par_mode`=0) and after 8 passes when it is grouped (`par_mode`=1).
- R6: `par_mode` is taken from the first accepted sample of a beam. Later changes to it have no effect until the next beam starts.
- R7: Two cycles after the final pass-end sample is accepted, `out_valid` goes high for exactly 512 consecutive cycles. During those cycles `out_bin` steps from 0 to 511 and the outputs carry each bin's sums.
- R8: `in_valid` is ignored from the cycle after the final pass-end sample up to and including the last readout cycle. Samples offered in that window change neither the results nor the pass count.
- R9: Once readout is finished, the next accepted sample belongs to pass 0 of a new beam.
- R10: While `out_valid` is low, `out_re` and `out_im` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode | input | 1 | 0: 32 passes per beam; 1: 8 passes per beam (grouped inputs) |
| in_valid | input | 1 | Sample present this cycle |
| in_last | input | 1 | Sample closes the current pass |
| in_bin | input | 9 | Frequency bin of the sample |
| in_re | input | 20 | Real part, signed |
| in_im | input | 20 | Imaginary part, signed |
| out_valid | output | 1 | Readout sample present |
| out_bin | output | 9 | Bin of the readout sample |
| out_re | output | 22 | Accumulated real part, signed |
| out_im | output | 22 | Accumulated imaginary part, signed |

## Verification
A wrong pass counter or a mode that is not latched at the start of the beam shows up as readout starting too early or too late. The output stream then disagrees with the expected bins from its first word. A lost forward of a pending write, or a wrong first-pass select, corrupts only the bins that were hit back to back or stale. Those errors appear at that bin's slot in the next readout, up to 512 cycles after it starts. An input that leaks through during readout shows up as a wrong sum in the following beam or as a beam boundary that moves.

// File: rtl/beam_acc_pkg.sv
// Shared types for the beam accumulator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package beam_acc_pkg;

    // Controller phases: taking samples, letting the last write land,
    // streaming bins out, and the final readout cycle.
    typedef enum logic [1:0] {
        ACC_RUN    = 2'd0,
        ACC_SETTLE = 2'd1,
        ACC_DRAIN  = 2'd2,
        ACC_TAIL   = 2'd3
    } acc_state_e;

endpackage

// File: rtl/beam_acc_mem.sv
// Simple dual-port store: one synchronous write port and one registered read port.
// Assumes: a read of the address being written in the same cycle returns the old
// contents (read-first); the caller forwards the pending value itself.
module beam_acc_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 44,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    // Write port: commit the new partial sum.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port: registered read, old data on a same-address collision.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end

endmodule

// File: rtl/beam_acc_lane.sv
// One adder lane (used once for the real part and once for the imaginary part).
// It holds the accepted sample for one cycle and forms the new bin sum from it.
// The base is zero on the first pass, the forwarded pending result when the
// previous write hit the same bin, and the memory word otherwise.
// Assumes: fwd_hit and mem_q are aligned with the cycle after acceptance.
module beam_acc_lane #(
    parameter int IN_W  = 20,
    parameter int ACC_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first_in,
    input  logic [IN_W-1:0]  smp_in,
    input  logic             fwd_hit,
    input  logic [ACC_W-1:0] mem_q,
    output logic [ACC_W-1:0] sum_out
);

    localparam int EXT_W = ACC_W - IN_W;

    logic [IN_W-1:0]  smp_q;
    logic             first_q;
    logic [ACC_W-1:0] fwd_q;
    logic [ACC_W-1:0] base;

    // Capture the sample and its pass-0 flag on acceptance; always remember the last sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q   <= '0;
            first_q <= 1'b0;
            fwd_q   <= '0;
        end else begin
            if (take) begin
                smp_q   <= smp_in;
                first_q <= first_in;
            end
            fwd_q <= sum_out;
        end
    end

    // Pick the base (zero, forwarded result or stored sum) and add the sign-extended sample.
    always_comb begin
        if (first_q) begin
            base = '0;
        end else if (fwd_hit) begin
            base = fwd_q;
        end else begin
            base = mem_q;
        end
        sum_out = base + {{EXT_W{smp_q[IN_W-1]}}, smp_q};
    end

endmodule

// File: rtl/beam_acc_ctrl.sv
// Pass counter, beam mode latch and readout sequencer.
// Assumes: every beam's pass 0 covers each bin it will later read out.
module beam_acc_ctrl
    import beam_acc_pkg::*;
#(
    parameter int NUM_BINS = 512,
    parameter int NUM_CH   = 32,
    parameter int GROUP    = 4,
    localparam int BIN_W   = $clog2(NUM_BINS),
    localparam int PASS_W  = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             par_mode,
    output logic             accept,
    output logic             first_pass,
    output logic             draining,
    output logic [BIN_W-1:0] drain_bin,
    output logic             out_valid,
    output logic [BIN_W-1:0] out_bin
);

    localparam logic [PASS_W-1:0] PASS_SER = PASS_W'(NUM_CH);
    localparam logic [PASS_W-1:0] PASS_PAR = PASS_W'(NUM_CH / GROUP);
    localparam logic [BIN_W-1:0]  BIN_TOP  = BIN_W'(NUM_BINS - 1);

    acc_state_e        state;
    logic [PASS_W-1:0] pass_q;
    logic              beam_open;
    logic              mode_q;
    logic [BIN_W-1:0]  drain_q;
    logic              mode_eff;
    logic [PASS_W-1:0] passes_eff;
    logic              last_pass;

    // Mode is live until the first sample of a beam, then held.
    always_comb begin
        mode_eff   = beam_open ? mode_q : par_mode;
        passes_eff = mode_eff ? PASS_PAR : PASS_SER;
        last_pass  = (pass_q == passes_eff - PASS_W'(1));
    end

    assign accept     = in_valid && (state == ACC_RUN);
    assign first_pass = (pass_q == '0);
    assign draining   = (state == ACC_DRAIN);
    assign drain_bin  = drain_q;

    // Step through passes, then settle, drain all bins and return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ACC_RUN;
            pass_q    <= '0;
            beam_open <= 1'b0;
            mode_q    <= 1'b0;
            drain_q   <= '0;
        end else begin
            case (state)
                ACC_RUN: begin
                    if (accept) begin
                        beam_open <= 1'b1;
                        mode_q    <= mode_eff;
                        if (in_last) begin
                            if (last_pass) begin
                                pass_q    <= '0;
                                beam_open <= 1'b0;
                                state     <= ACC_SETTLE;
                            end else begin
                                pass_q <= pass_q + PASS_W'(1);
                            end
                        end
                    end
                end
                ACC_SETTLE: begin
                    drain_q <= '0;
                    state   <= ACC_DRAIN;
                end
                ACC_DRAIN: begin
                    drain_q <= drain_q + BIN_W'(1);
                    if (drain_q == BIN_TOP) begin
                        state <= ACC_TAIL;
                    end
                end
                default: begin
                    state <= ACC_RUN;
                end
            endcase
        end
    end

    // Output qualifiers line up with the registered memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bin   <= '0;
        end else begin
            out_valid <= (state == ACC_DRAIN);
            out_bin   <= drain_q;
        end
    end

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q < passes_eff);                                               // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        beam_open && $past(beam_open) |-> $stable(mode_q));                 // R6
    AST_READOUT_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state, 2) == ACC_SETTLE);                // R7

endmodule

// File: rtl/beam_acc_top.sv
// Top: bin-indexed read-add-write accumulator with readout switching.
// A sample accepted at edge E reads its bin at E. At E+1 the new sum is formed
// and written back. A write to the same bin at E is forwarded.
// Assumes: in_bin lies below NUM_BINS; pass 0 of each beam covers all bins.
module beam_acc_top #(
    parameter int NUM_BINS = 512,
    parameter int IN_W     = 20,
    parameter int ACC_W    = 22,
    parameter int NUM_CH   = 32,
    parameter int GROUP    = 4,
    localparam int BIN_W   = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_mode,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [BIN_W-1:0] in_bin,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    output logic             out_valid,
    output logic [BIN_W-1:0] out_bin,
    output logic [ACC_W-1:0] out_re,
    output logic [ACC_W-1:0] out_im
);

    localparam int LANES = 2;

    logic             accept;
    logic             first_pass;
    logic             draining;
    logic [BIN_W-1:0] drain_bin;
    logic [BIN_W-1:0] rd_addr;
    logic [LANES*ACC_W-1:0] rd_q;
    logic [LANES*ACC_W-1:0] wr_data;
    logic             s1_valid;
    logic [BIN_W-1:0] s1_bin;
    logic             fwd_hit;
    logic [IN_W-1:0]  lane_in  [LANES];
    logic [ACC_W-1:0] lane_mem [LANES];
    logic [ACC_W-1:0] lane_sum [LANES];

    beam_acc_ctrl #(
        .NUM_BINS (NUM_BINS),
        .NUM_CH   (NUM_CH),
        .GROUP    (GROUP)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .par_mode   (par_mode),
        .accept     (accept),
        .first_pass (first_pass),
        .draining   (draining),
        .drain_bin  (drain_bin),
        .out_valid  (out_valid),
        .out_bin    (out_bin)
    );

    // The read port serves the accumulation during input and the readout while draining.
    assign rd_addr = draining ? drain_bin : in_bin;

    // Stage-1 tracking of the pending write and same-bin detection for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_bin   <= '0;
            fwd_hit  <= 1'b0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_bin <= in_bin;
            end
            fwd_hit <= accept && s1_valid && (s1_bin == in_bin);
        end
    end

    assign lane_in[0] = in_re;
    assign lane_in[1] = in_im;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mem[g] = rd_q[g*ACC_W +: ACC_W];
        assign wr_data[g*ACC_W +: ACC_W] = lane_sum[g];

        beam_acc_lane #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (accept),
            .first_in (first_pass),
            .smp_in   (lane_in[g]),
            .fwd_hit  (fwd_hit),
            .mem_q    (lane_mem[g]),
            .sum_out  (lane_sum[g])
        );
    end

    beam_acc_mem #(
        .DEPTH (NUM_BINS),
        .DW    (LANES * ACC_W)
    ) mem_i (
        .clk   (clk),
        .we    (s1_valid),
        .waddr (s1_bin),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_q)
    );

    // Output switch: sums reach the port only during readout.
    assign out_re = out_valid ? lane_mem[0] : '0;
    assign out_im = out_valid ? lane_mem[1] : '0;

    AST_NO_WRITE_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !s1_valid);                                           // R8
    AST_READOUT_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_bin == '0);                                // R7
    AST_READOUT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> out_bin == $past(out_bin) + 1'b1); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid);                                             // R1

endmodule

// File: tb/beam_acc_top_tb_top.sv
// Scoreboard bench: the driver updates a reference model and queues each finished
// beam; the monitor pops and compares while readout runs.
module beam_acc_top_tb_top;

    localparam int NB = 512;
    localparam int IW = 20;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          par_mode;
    logic          in_valid;
    logic          in_last;
    logic [8:0]    in_bin;
    logic [IW-1:0] in_re;
    logic [IW-1:0] in_im;
    logic          out_valid;
    logic [8:0]    out_bin;
    logic [AW-1:0] out_re;
    logic [AW-1:0] out_im;

    always #2 clk = ~clk;

    beam_acc_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_mode  (par_mode),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_bin    (in_bin),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [AW-1:0] m_re [NB];
    logic [AW-1:0] m_im [NB];
    int    m_pass = 0;
    int    m_passes = 32;
    bit    m_open = 0;
    bit    par_sel = 0;
    string beam_tag = "";

    int            q_bin [$];
    logic [AW-1:0] q_re  [$];
    logic [AW-1:0] q_im  [$];
    string         q_tag [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Driver: offer one sample and update the reference model (R2, R3, R5, R6).
    task automatic send(input int bin, input int re, input int im, input bit last);
        logic signed [IW-1:0] r20;
        logic signed [IW-1:0] i20;
        logic signed [AW-1:0] rs;
        logic signed [AW-1:0] is;
        @(negedge clk);
        r20 = re[IW-1:0];
        i20 = im[IW-1:0];
        rs = r20;
        is = i20;
        in_valid = 1'b1;
        in_last  = last;
        in_bin   = bin[8:0];
        in_re    = r20;
        in_im    = i20;
        par_mode = par_sel;
        if (!m_open) begin
            m_open   = 1;
            m_passes = par_sel ? 8 : 32;
        end
        if (m_pass == 0) begin
            m_re[bin] = rs;
            m_im[bin] = is;
        end else begin
            m_re[bin] = m_re[bin] + rs;
            m_im[bin] = m_im[bin] + is;
        end
        if (last) begin
            m_pass++;
            if (m_pass == m_passes) begin
                for (int b = 0; b < NB; b++) begin
                    q_bin.push_back(b);
                    q_re.push_back(m_re[b]);
                    q_im.push_back(m_im[b]);
                    q_tag.push_back(beam_tag);
                end
                m_pass = 0;
                m_open = 0;
            end
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int k = 1; k < n; k++) @(negedge clk);
    endtask

    // After the final pass: keep offering junk until readout ends (R8).
    task automatic drain_noise();
        bit seen = 0;
        bit done = 0;
        for (int k = 0; k < 1200 && !done; k++) begin
            @(negedge clk);
            if (seen && !out_valid) begin
                done = 1;
            end else begin
                if (out_valid) seen = 1;
                in_valid = 1'b1;
                in_last  = 1'b1;
                in_bin   = 9'((k * 7) % NB);
                in_re    = IW'(12345);
                in_im    = IW'(-4321);
                par_mode = ~par_mode;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(done, "R7", "readout did not complete", 0, 1);
    endtask

    // Monitor: compare every readout word and the idle output level (R7, R10).
    initial begin
        int run = 0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n === 1'b1) begin
                if (out_valid) begin
                    if (q_bin.size() == 0) begin
                        check(0, "R5", "out_valid with no finished beam", 1, 0);
                    end else begin
                        int            eb;
                        logic [AW-1:0] er;
                        logic [AW-1:0] ei;
                        string         tg;
                        eb = q_bin.pop_front();
                        er = q_re.pop_front();
                        ei = q_im.pop_front();
                        tg = q_tag.pop_front();
                        check(int'(out_bin) == eb, "R7", "readout bin", out_bin, eb);
                        check(out_re == er, tg, "real sum", out_re, er);
                        check(out_im == ei, tg, "imag sum", out_im, ei);
                    end
                    run++;
                end else begin
                    check(out_re == '0 && out_im == '0, "R10", "idle output", out_re, 0);
                    if (run != 0) begin
                        check(run == NB, "R7", "valid run length", run, NB);
                        run = 0;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        par_mode = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_bin   = '0;
        in_re    = '0;
        in_im    = '0;
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(out_re == '0, "R1", "out_re in reset", out_re, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // Beam A: serial mode, same-bin bursts for forwarding (R2 R3 R4 R5).
        par_sel  = 0;
        beam_tag = "R2 R3 R4 R5";
        for (int b = 0; b < NB; b++) send(b, b * 37 - 9000, 77 - b * 11, b == NB - 1);
        for (int p = 1; p < 32; p++) begin
            send(7, p * 100, -p, 0);
            send(7, p * 3 + 1, 5, 0);
            send(7, -50, p, 0);
            send(8, p, p, 0);
            send(7, 11, -11, 0);
            idle(2);
            send(7, p, 1, 0);
            send((p * 13) % NB, 1000, -1000, 1);
            idle(1);
        end
        drain_noise();
        idle(3);

        // Beam B: grouped mode latched at the first sample, then par_mode flips (R6 R8 R9).
        par_sel  = 1;
        beam_tag = "R5 R6 R8 R9";
        for (int b = 0; b < NB; b++) begin
            send(b, b * 5, -b, b == NB - 1);
            par_sel = 0;
        end
        for (int p = 1; p < 8; p++) begin
            send((p * 29) % NB, -700 * p, 300, 0);
            send((p * 29) % NB, 4, 4, 0);
            send(NB - 1, p, -p, 1);
        end
        drain_noise();
        idle(2);

        // Beam C: grouped mode, bin 3 driven past the 22-bit range (R3 R9).
        par_sel  = 1;
        beam_tag = "R3 R9";
        for (int b = 0; b < NB; b++) begin
            if (b == 3) send(b, 524287, -524288, 0);
            else        send(b, 0, 0, b == NB - 1);
        end
        for (int p = 1; p < 8; p++) send(3, 524287, -524288, 1);
        drain_noise();
        idle(4);

        check(q_bin.size() == 0, "R7", "beams left unread", q_bin.size(), 0);
        finish_run();
    end

endmodule